// File: doc/BRIEF.md
# Addressable Bit Latch with Demultiplexer Mode

This block keeps a row of single-bit storage cells. One cell is picked at a time by a binary address. A two-pin control pair selects what happens at each rising clock edge. The picked cell can be written while the others keep their values. Every cell can hold. The row can act as a one-of-N active-high demultiplexer, in which only the addressed output may be high. The whole row can be cleared.

A typical use is serial-to-parallel conversion: a bit stream is written one address per cycle. The same part can also serve as a decoder, by tying the data input high and using demultiplex mode.

The storage is a clocked register rather than a set of transparent latches. The control pair, the address and the data bit are sampled on each rising edge, and the outputs come straight from the register. An asynchronous active-low reset empties the row.

The block has no streaming interface. Every pin is a plain level-sensitive control or data pin, so there is no valid/ready handshake and no back-pressure. Software should still change more than one address bit at a time only in hold mode. The clocked model tolerates such changes in any mode, because it samples the address only at the edge.

Top module: `addr_latch_demux`

## Requirements
- R1: While `rst_n` is low, `q` is all zeros, and it becomes all zeros without waiting for a clock edge.
- R2: The mode at each rising edge is chosen by `{en_n, clr_n}`: 2'b01 is write, 2'b11 is hold, 2'b00 is demultiplex and 2'b10 is clear.
- R3: In write mode, after the edge the addressed bit `q[addr]` equals the `din` sampled at that edge.
- R4: In write mode, every bit other than `q[addr]` keeps its value across the edge.
- R5: In hold mode, all of `q` keeps its value, whatever `addr` and `din` are.
- R6: In demultiplex mode, after the edge `q[addr]` equals `din` and every other bit is 0.
- R7: In clear mode, after the edge all of `q` is 0, whatever `addr` and `din` are.
- R8: The address is unsigned binary with bit 0 least significant; the value k selects `q[k]` (3'b001 selects `q[1]`, 3'b111 selects `q[7]`).
- R9: The pattern left by demultiplex or clear mode is the stored state, so a following hold cycle keeps exactly that pattern.
- R10: Writes on consecutive cycles to different addresses accumulate, and each one leaves the earlier ones in place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low, clears all bits |
| en_n | input | 1 | Active-low enable, first bit of the mode pair |
| clr_n | input | 1 | Active-low clear, second bit of the mode pair |
| addr | input | AW | Binary index of the selected bit |
| din | input | 1 | Data bit for write and demultiplex modes |
| q | output | N | Stored bits, one per address |

## Verification
The hardest case to reach from the ports is showing that a write, or a hold with a busy address, leaves the unaddressed bits alone. A row of zeros hides any stray write. The stimulus therefore first builds an irregular pattern, 8'hA5, with back-to-back writes. It then sweeps every address with both data values in hold mode, and checks the full pattern after each step. Demultiplex and clear modes are each followed by a hold cycle with the inputs still changing. This shows that the forced pattern has really become the stored state, not a passing combinational value.

// File: rtl/alat_pkg.sv
package alat_pkg;
  // Mode code equals the raw pair {en_n, clr_n}
  typedef enum logic [1:0] {
    MODE_DEMUX = 2'b00,
    MODE_WRITE = 2'b01,
    MODE_CLEAR = 2'b10,
    MODE_HOLD  = 2'b11
  } mode_e;
endpackage

// File: rtl/alat_mode_dec.sv
module alat_mode_dec
  import alat_pkg::*;
(
  input  logic  en_n,
  input  logic  clr_n,
  output mode_e mode
);
  always_comb begin
    case ({en_n, clr_n})
      2'b00:   mode = MODE_DEMUX;
      2'b01:   mode = MODE_WRITE;
      2'b10:   mode = MODE_CLEAR;
      default: mode = MODE_HOLD;
    endcase
  end
endmodule

// File: rtl/alat_sel_dec.sv
module alat_sel_dec #(
  parameter int N  = 8,
  parameter int AW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [AW-1:0] addr,
  output logic [N-1:0]  sel
);
  // One-hot select: bit k is high when the binary address equals k
  for (genvar k = 0; k < N; k++) begin : g_sel
    assign sel[k] = (addr == AW'(k));
  end
endmodule

// File: rtl/alat_bit_cell.sv
module alat_bit_cell
  import alat_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mode_e mode,
  input  logic  sel,
  input  logic  din,
  output logic  q
);
  logic nxt;

  always_comb begin
    case (mode)
      MODE_WRITE: nxt = sel ? din : q;
      MODE_DEMUX: nxt = sel & din;
      MODE_CLEAR: nxt = 1'b0;
      default:    nxt = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= nxt;
  end
endmodule

// File: rtl/addr_latch_demux.sv
module addr_latch_demux
  import alat_pkg::*;
#(
  parameter int N  = 8,
  parameter int AW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_n,
  input  logic          clr_n,
  input  logic [AW-1:0] addr,
  input  logic          din,
  output logic [N-1:0]  q
);
  mode_e        mode;
  logic [N-1:0] sel;

  alat_mode_dec u_mode (
    .en_n  (en_n),
    .clr_n (clr_n),
    .mode  (mode)
  );

  alat_sel_dec #(.N(N), .AW(AW)) u_sel (
    .addr (addr),
    .sel  (sel)
  );

  for (genvar b = 0; b < N; b++) begin : g_cell
    alat_bit_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .mode  (mode),
      .sel   (sel[b]),
      .din   (din),
      .q     (q[b])
    );
  end
endmodule

// File: rtl/alat_chk.sv
module alat_chk #(
  parameter int N  = 8,
  parameter int AW = (N > 1) ? $clog2(N) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en_n,
  input logic          clr_n,
  input logic [AW-1:0] addr,
  input logic          din,
  input logic [N-1:0]  q
);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  // R1
  reset_zero_chk: assert property (@(posedge clk) !rst_n |-> q == '0);

  // R3
  write_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n && clr_n) |=> q[$past(addr)] == $past(din));

  // R4
  write_others_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n && clr_n) |=> ((q ^ $past(q)) & ~(ONE << $past(addr))) == '0);

  // R5
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_n && clr_n) |=> $stable(q));

  // R6
  demux_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n && !clr_n) |=> $onehot0(q) && (q[$past(addr)] == $past(din)));

  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_n && !clr_n) |=> q == '0);
endmodule

bind addr_latch_demux alat_chk #(.N(N), .AW(AW)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .en_n  (en_n),
  .clr_n (clr_n),
  .addr  (addr),
  .din   (din),
  .q     (q)
);

// File: tb/sim_addr_latch_demux.sv
`timescale 1ns/1ps
module sim_addr_latch_demux;
  localparam int N  = 8;
  localparam int AW = 3;
  localparam int NV = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en_n = 1'b1;
  logic          clr_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          din = 1'b0;
  logic [N-1:0]  q;

  int checks = 0;
  int bad = 0;
  logic [N-1:0] model = '0;

  always #2.5 clk = ~clk;

  addr_latch_demux #(.N(N), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .clr_n(clr_n),
    .addr(addr), .din(din), .q(q)
  );

  // {en_n, clr_n, addr, din, expected q}; R2 codes: 01 write, 11 hold, 00 demux, 10 clear
  localparam logic [13:0] VEC [NV] = '{
    {2'b01, 3'd3, 1'b1, 8'h08},  // R3 R8
    {2'b01, 3'd0, 1'b1, 8'h09},  // R10
    {2'b01, 3'd7, 1'b1, 8'h89},  // R10
    {2'b01, 3'd3, 1'b0, 8'h81},  // R4
    {2'b11, 3'd5, 1'b1, 8'h81},  // R5
    {2'b11, 3'd2, 1'b0, 8'h81},  // R5
    {2'b00, 3'd4, 1'b1, 8'h10},  // R6
    {2'b11, 3'd6, 1'b1, 8'h10},  // R9
    {2'b00, 3'd6, 1'b0, 8'h00},  // R6
    {2'b01, 3'd1, 1'b1, 8'h02},
    {2'b01, 3'd2, 1'b1, 8'h06},  // R10
    {2'b10, 3'd7, 1'b1, 8'h00},  // R7
    {2'b11, 3'd0, 1'b1, 8'h00},  // R9
    {2'b01, 3'd5, 1'b1, 8'h20},
    {2'b00, 3'd7, 1'b1, 8'h80},  // R8
    {2'b01, 3'd6, 1'b1, 8'hC0}
  };

  task automatic check(input logic [N-1:0] exp, input string req);
    checks++;
    if (q !== exp) begin
      bad++;
      $display("FAIL %s: q=%h expected=%h", req, q, exp);
    end
  endtask

  function automatic string req_of(input logic [1:0] m);
    case (m)
      2'b01:   return "R3/R4";
      2'b11:   return "R5";
      2'b00:   return "R6";
      default: return "R7";
    endcase
  endfunction

  // Drive one cycle, update the bench model from the requirements, check after the edge
  task automatic step(input logic e, input logic c, input logic [AW-1:0] a,
                      input logic d, input string req);
    @(negedge clk);
    en_n = e; clr_n = c; addr = a; din = d;
    case ({e, c})
      2'b01: model[a] = d;
      2'b11: model = model;
      2'b00: begin model = '0; model[a] = d; end
      default: model = '0;
    endcase
    @(posedge clk);
    #1;
    check(model, req);
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog: q=%h expected=completion", q);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #12;
    check('0, "R1");
    @(negedge clk);
    rst_n = 1'b1;

    // Table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {en_n, clr_n, addr, din} = VEC[i][13:8];
      @(posedge clk);
      #1;
      check(VEC[i][7:0], req_of(VEC[i][13:12]));
    end
    model = q;

    // R8 R6: demux every address, both data values
    for (int a = 0; a < N; a++) begin
      step(1'b0, 1'b0, AW'(a), 1'b1, "R6 R8");
      step(1'b0, 1'b0, AW'(a), 1'b0, "R6");
    end

    // R10: back-to-back writes build 8'hA5
    step(1'b1, 1'b0, '0, 1'b1, "R7");
    for (int a = 0; a < N; a++)
      step(1'b0, 1'b1, AW'(a), 1'(8'hA5 >> a), "R10");
    check(8'hA5, "R10");

    // R5: hold with every address and data value
    for (int a = 0; a < N; a++) begin
      step(1'b1, 1'b1, AW'(a), 1'b1, "R5");
      step(1'b1, 1'b1, AW'(a), 1'b0, "R5");
    end
    check(8'hA5, "R5");

    // R4: overwrite single bits, neighbours kept
    step(1'b0, 1'b1, 3'd0, 1'b0, "R3 R4");
    step(1'b0, 1'b1, 3'd1, 1'b1, "R3 R4");
    check(8'hA6, "R4");

    // R7 then R9
    step(1'b1, 1'b0, 3'd5, 1'b1, "R7");
    step(1'b1, 1'b1, 3'd5, 1'b1, "R9");
    check('0, "R9");

    // R1: asynchronous reset mid-cycle
    step(1'b0, 1'b1, 3'd4, 1'b1, "R3");
    @(negedge clk);
    en_n = 1'b1; clr_n = 1'b1;
    #1 rst_n = 1'b0;
    #0.5;
    check('0, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    model = '0;
    step(1'b1, 1'b1, 3'd2, 1'b1, "R1 R5");

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule